// File: doc/BRIEF.md
# UART Interrupt and FIFO Status Controller

This block is the register-facing half of a high-rate serial port. It keeps a 64-entry receive queue and a 64-entry transmit queue, and it exposes them through five 32-bit word registers on a simple single-cycle bus: a data port, a fill-level register, an interrupt status register, a control register and a rate register. The bit-level transceiver is outside the block. It reaches the block through a push strobe with byte, framing and break flags on the receive side, and through a pop strobe with a head-byte output on the transmit side. It also supplies a one-cycle tick per bit period.

The block turns queue fill levels, receive errors and receive inactivity into interrupt sources. The transmit, framing, break and overrun sources are latched and cleared by writing 1. The receive-trigger and receive-timeout sources are live levels. A single `irq` output is the OR of these sources, each gated by one of three enables. The block also applies optional clear-to-send gating to the transmit queue, and it drives a request-to-send output from the receive fill level.

The receive-idle detector is a three-state machine. `TO_IDLE` waits for data. On entry to `TO_COUNT` it counts character times (10 ticks each) since the last receive push or pop. In `TO_FIRED` it reports a timeout. The transitions are:
- `TO_IDLE`→`TO_COUNT` when timing is enabled and the receive queue holds data.
- `TO_COUNT`→`TO_COUNT`, with the counters restarted, on any push or pop.
- `TO_COUNT`→`TO_FIRED` when the programmed number of character times has elapsed.
- `TO_FIRED`→`TO_COUNT` on a push or pop.
- `TO_COUNT`/`TO_FIRED`→`TO_IDLE` when the queue is empty or timing is disabled.

Top module: `uart_irq_ctl`

## Requirements
- R1: After reset, the level, status, control and rate registers read 0, `irq` is 0, `tx_avail` is 0, `rts_out` is 1, and a data-port read returns 0x100.
- R2: A read of the data port (address 0x00) pops the receive queue in arrival order. It returns the byte in bits 7:0, the framing flag in bit 9 and the break flag in bit 10. When the queue is empty it returns bit 8 set with all other bits 0 and pops nothing.
- R3: The level register (address 0x04) holds the receive count in bits 7:0 and the transmit count in bits 15:8.
- R4: A push into a full receive queue (64 entries) is dropped and sets status bit 5. Bit 5 stays set until 1 is written to it at address 0x08.
- R5: A data-port write pushes bits 7:0 into the transmit queue. A write to a full queue is ignored, and `tx_byte` shows the bytes in write order.
- R6: Status bit 1 is high while the receive count is at or above the trigger level. Control bits 4:2 set that level: codes 0..5 give 1, 4, 8, 16, 32 and 48 entries, and codes 6 and 7 give 48.
- R7: Status bit 0 is set by a transmit pop that leaves the count at or below the level in control bits 1:0, where codes 0..3 give 0, 4, 8 and 16. Writing 1 to bit 6 also sets bit 0, and writing 1 to bit 0 clears it. Bit 6 reads as 0.
- R8: Accepting a byte flagged as a framing error sets status bit 3. Accepting a byte flagged as break sets status bit 4. Each of these bits is cleared by writing 1 to it.
- R9: Status bit 2 becomes 1 when the receive queue has held data with no push or pop for N character times of 10 baud ticks. Control bits 17:16 set N: codes 1..3 give 4, 8 and 16, and code 0 disables the timeout. The bit drops in the cycle after a push or pop, or when the queue empties.
- R10: `irq` is the OR of three terms: (status bit 0 AND control bit 5), ((bit 1 OR bit 2) AND control bit 6), and ((bit 3 OR bit 4 OR bit 5) AND control bit 7).
- R11: When control bit 14 is set, `tx_avail` is 0 and `tx_pop` has no effect unless `cts_in` XOR control bit 15 is 1. When bit 14 is clear, `tx_avail` is 1 whenever the transmit queue holds data.
- R12: `rts_out` is a ready value XOR control bit 21. The ready value is 1 when control bit 18 is clear. When bit 18 is set, ready is 1 only while the receive count is below the level in bits 20:19, where codes 0..3 give 8, 16, 32 and 48.
- R13: The control register (address 0x0C) reads back its low 22 bits. The rate register (address 0x10) reads back its low 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rx_push | input | 1 | Transceiver delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_ferr | input | 1 | Framing error on this byte |
| rx_brk | input | 1 | Byte is break data |
| tx_pop | input | 1 | Transceiver takes the head byte |
| tx_byte | output | 8 | Head of the transmit queue |
| tx_avail | output | 1 | Transmit data is present and allowed |
| baud_tick | input | 1 | One pulse per bit period |
| cts_in | input | 1 | Clear-to-send input |
| rts_out | output | 1 | Request-to-send output |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume the following about the inputs:
- `bus_sel` is held for exactly one cycle per access, so a data-port read pops exactly one entry.
- A status write never lands in the same cycle as a hardware event that sets the same bit.
- `baud_tick` is a single-cycle pulse, or is held high when a tick on every clock is intended.

The directed stimulus drives every strobe for one clock, from the falling edge to just after the next rising edge. It writes status only while the receive and transmit sides are idle, and it holds `baud_tick` high only during the timeout scenario. With those limits, the timeout crossing falls well inside the 30- and 50-cycle sample windows.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    typedef enum logic [1:0] {
        TO_IDLE,
        TO_COUNT,
        TO_FIRED
    } tmo_state_e;

    localparam logic [4:0] A_DATA  = 5'h00;
    localparam logic [4:0] A_LEVEL = 5'h04;
    localparam logic [4:0] A_STAT  = 5'h08;
    localparam logic [4:0] A_CTRL  = 5'h0C;
    localparam logic [4:0] A_RATE  = 5'h10;

    localparam int ST_W      = 7;
    localparam int CTRL_W    = 22;
    localparam int RATE_W    = 8;
    localparam int LVL_W     = 8;

    localparam int C_TXTRIG  = 0;
    localparam int C_RXTRIG  = 2;
    localparam int C_TXIE    = 5;
    localparam int C_RXIE    = 6;
    localparam int C_ERRIE   = 7;
    localparam int C_CTS_EN  = 14;
    localparam int C_CTS_INV = 15;
    localparam int C_TMO     = 16;
    localparam int C_RTS_EN  = 18;
    localparam int C_RTS_LVL = 19;
    localparam int C_RTS_INV = 21;

    // write-1-to-clear bits of the status word: 0, 3, 4, 5
    localparam logic [ST_W-1:0] W1C_MASK = 7'b0111001;

    function automatic logic [LVL_W-1:0] rx_trig_lvl(input logic [2:0] code);
        case (code)
            3'd0:    return 8'd1;
            3'd1:    return 8'd4;
            3'd2:    return 8'd8;
            3'd3:    return 8'd16;
            3'd4:    return 8'd32;
            default: return 8'd48;
        endcase
    endfunction

    function automatic logic [LVL_W-1:0] tx_trig_lvl(input logic [1:0] code);
        case (code)
            2'd0:    return 8'd0;
            2'd1:    return 8'd4;
            2'd2:    return 8'd8;
            default: return 8'd16;
        endcase
    endfunction

    function automatic logic [LVL_W-1:0] rts_lvl(input logic [1:0] code);
        case (code)
            2'd0:    return 8'd8;
            2'd1:    return 8'd16;
            2'd2:    return 8'd32;
            default: return 8'd48;
        endcase
    endfunction

    function automatic logic [LVL_W-1:0] tmo_chars(input logic [1:0] code);
        case (code)
            2'd0:    return 8'd0;
            2'd1:    return 8'd4;
            2'd2:    return 8'd8;
            default: return 8'd16;
        endcase
    endfunction

endpackage

// File: rtl/uirq_fifo.sv
module uirq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        head    = mem[rptr];
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + AW'(1);
            if (do_pop)  rptr <= rptr + AW'(1);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R4 / R5: never beyond capacity, and a push into a full queue leaves the count alone
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_full_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/uirq_idle_timer.sv
module uirq_idle_timer
    import uirq_pkg::*;
#(
    parameter int BITS_PER_CHAR = 10,
    parameter int MAX_CHARS     = 16,
    localparam int BW           = $clog2(BITS_PER_CHAR),
    localparam int CHW          = $clog2(MAX_CHARS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] code,
    input  logic       rx_nonempty,
    input  logic       activity,
    input  logic       baud_tick,
    output logic       expired
);

    tmo_state_e     state, nstate;
    logic [BW-1:0]  bit_cnt;
    logic [CHW-1:0] chr_cnt;
    logic [CHW-1:0] limit;
    logic           enabled, char_done, reached;

    always_comb begin
        limit     = CHW'(tmo_chars(code));
        enabled   = (code != 2'd0);
        char_done = baud_tick && (bit_cnt == BW'(BITS_PER_CHAR - 1));
        reached   = char_done && ((chr_cnt + CHW'(1)) == limit);
    end

    always_comb begin
        nstate = state;
        unique case (state)
            TO_IDLE:
                if (enabled && rx_nonempty) nstate = TO_COUNT;
            TO_COUNT:
                if (!enabled || !rx_nonempty) nstate = TO_IDLE;
                else if (activity)            nstate = TO_COUNT;
                else if (reached)             nstate = TO_FIRED;
            TO_FIRED:
                if (!enabled || !rx_nonempty) nstate = TO_IDLE;
                else if (activity)            nstate = TO_COUNT;
            default: nstate = TO_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TO_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            chr_cnt <= '0;
        end else if (state != TO_COUNT || activity) begin
            bit_cnt <= '0;
            chr_cnt <= '0;
        end else if (baud_tick) begin
            if (char_done) begin
                bit_cnt <= '0;
                chr_cnt <= chr_cnt + CHW'(1);
            end else begin
                bit_cnt <= bit_cnt + BW'(1);
            end
        end
    end

    always_comb begin
        expired = (state == TO_FIRED);
    end

    // R9: the timeout only appears after data was waiting, and vanishes once disabled
    assert_fire_needs_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(rx_nonempty));
    assert_off_when_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |=> !expired);

endmodule

// File: rtl/uirq_irq_status.sv
module uirq_irq_status
    import uirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_tx,
    input  logic            sw_tx_set,
    input  logic            set_fe,
    input  logic            set_brk,
    input  logic            set_oe,
    input  logic [ST_W-1:0] clr,
    input  logic            trig,
    input  logic            tmo,
    input  logic            en_tx,
    input  logic            en_rx,
    input  logic            en_err,
    output logic [ST_W-1:0] status,
    output logic            irq
);

    logic tx_l, fe_l, brk_l, oe_l;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_l  <= 1'b0;
            fe_l  <= 1'b0;
            brk_l <= 1'b0;
            oe_l  <= 1'b0;
        end else begin
            tx_l  <= set_tx || sw_tx_set || (tx_l && !clr[0]);
            fe_l  <= set_fe  || (fe_l  && !clr[3]);
            brk_l <= set_brk || (brk_l && !clr[4]);
            oe_l  <= set_oe  || (oe_l  && !clr[5]);
        end
    end

    always_comb begin
        status = {1'b0, oe_l, brk_l, fe_l, tmo, trig, tx_l};
        irq    = (en_tx && tx_l) || (en_rx && (trig || tmo)) ||
                 (en_err && (fe_l || brk_l || oe_l));
    end

    // R4: overrun stays latched until cleared
    assert_oe_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && !clr[5]) |=> status[5]);
    // R8: write-1 clears framing when no new framing event arrives
    assert_w1c_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[3] && !set_fe) |=> !status[3]);
    // R10: no interrupt without some enable
    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en_tx || en_rx || en_err));

endmodule

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl
    import uirq_pkg::*;
#(
    parameter int FIFO_DEPTH    = 64,
    parameter int BITS_PER_CHAR = 10,
    localparam int CW           = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rx_push,
    input  logic [7:0]  rx_byte,
    input  logic        rx_ferr,
    input  logic        rx_brk,
    input  logic        tx_pop,
    output logic [7:0]  tx_byte,
    output logic        tx_avail,
    input  logic        baud_tick,
    input  logic        cts_in,
    output logic        rts_out,
    output logic        irq
);

    logic [CTRL_W-1:0] ctrl_q;
    logic [RATE_W-1:0] rate_q;

    logic            rd_data, wr_data, wr_stat, wr_ctrl, wr_rate;
    logic [9:0]      rx_head;
    logic [CW-1:0]   rx_cnt, tx_cnt;
    logic            rx_full, rx_empty, tx_full, tx_empty;
    logic [LVL_W-1:0] rx_lvl, tx_lvl;
    logic            rx_acc, rx_take, tx_allow, tx_take;
    logic            set_tx, set_oe, trig, tmo, rts_ready;
    logic [ST_W-1:0] status, clr;
    logic            unused_bits;

    always_comb begin
        rd_data = bus_sel && !bus_wr && (bus_addr == A_DATA);
        wr_data = bus_sel &&  bus_wr && (bus_addr == A_DATA);
        wr_stat = bus_sel &&  bus_wr && (bus_addr == A_STAT);
        wr_ctrl = bus_sel &&  bus_wr && (bus_addr == A_CTRL);
        wr_rate = bus_sel &&  bus_wr && (bus_addr == A_RATE);
        unused_bits = ^bus_wdata[31:CTRL_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            rate_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
            if (wr_rate) rate_q <= bus_wdata[RATE_W-1:0];
        end
    end

    uirq_fifo #(.W(10), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .din   ({rx_brk, rx_ferr, rx_byte}),
        .pop   (rd_data),
        .head  (rx_head),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    uirq_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_data),
        .din   (bus_wdata[7:0]),
        .pop   (tx_pop && tx_allow),
        .head  (tx_byte),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    always_comb begin
        rx_lvl    = LVL_W'(rx_cnt);
        tx_lvl    = LVL_W'(tx_cnt);
        rx_take   = rd_data && !rx_empty;
        rx_acc    = rx_push && (!rx_full || rx_take);
        tx_allow  = !ctrl_q[C_CTS_EN] || (cts_in ^ ctrl_q[C_CTS_INV]);
        tx_avail  = !tx_empty && tx_allow;
        tx_take   = tx_pop && tx_avail;
        set_tx    = tx_take && ((tx_lvl - LVL_W'(1)) <= tx_trig_lvl(ctrl_q[C_TXTRIG +: 2]));
        set_oe    = rx_push && rx_full && !rx_take;
        trig      = rx_lvl >= rx_trig_lvl(ctrl_q[C_RXTRIG +: 3]);
        clr       = wr_stat ? (bus_wdata[ST_W-1:0] & W1C_MASK) : '0;
        rts_ready = !ctrl_q[C_RTS_EN] || (rx_lvl < rts_lvl(ctrl_q[C_RTS_LVL +: 2]));
        rts_out   = rts_ready ^ ctrl_q[C_RTS_INV];
    end

    uirq_idle_timer #(.BITS_PER_CHAR(BITS_PER_CHAR), .MAX_CHARS(16)) u_idle (
        .clk         (clk),
        .rst_n       (rst_n),
        .code        (ctrl_q[C_TMO +: 2]),
        .rx_nonempty (!rx_empty),
        .activity    (rx_acc || rx_take),
        .baud_tick   (baud_tick),
        .expired     (tmo)
    );

    uirq_irq_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_tx    (set_tx),
        .sw_tx_set (wr_stat && bus_wdata[6]),
        .set_fe    (rx_acc && rx_ferr),
        .set_brk   (rx_acc && rx_brk),
        .set_oe    (set_oe),
        .clr       (clr),
        .trig      (trig),
        .tmo       (tmo),
        .en_tx     (ctrl_q[C_TXIE]),
        .en_rx     (ctrl_q[C_RXIE]),
        .en_err    (ctrl_q[C_ERRIE]),
        .status    (status),
        .irq       (irq)
    );

    always_comb begin
        case (bus_addr)
            A_DATA:  bus_rdata = rx_empty ? 32'h0000_0100
                               : {21'b0, rx_head[9], rx_head[8], 1'b0, rx_head[7:0]};
            A_LEVEL: bus_rdata = {16'b0, tx_lvl, rx_lvl};
            A_STAT:  bus_rdata = {{(32-ST_W){1'b0}}, status};
            A_CTRL:  bus_rdata = {{(32-CTRL_W){1'b0}}, ctrl_q};
            A_RATE:  bus_rdata = {{(32-RATE_W){1'b0}}, rate_q};
            default: bus_rdata = 32'b0;
        endcase
    end

    // R2 / R3: a data-port read with no push lowers the receive level by one
    assert_pop_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !rx_empty && !rx_push) |=> (rx_lvl == $past(rx_lvl) - LVL_W'(1)));
    // R5: a data write into a full transmit queue leaves it full
    assert_tx_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && tx_full && !tx_pop) |=> (tx_lvl == LVL_W'(FIFO_DEPTH)));
    // R11: transmit data is never offered while clear-to-send blocks it
    assert_cts_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[C_CTS_EN] && (cts_in == ctrl_q[C_CTS_INV])) |-> !tx_avail);

endmodule

// File: tb/sim_uart_irq_ctl.sv
module sim_uart_irq_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rx_push = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_avail;
    logic        baud_tick = 1'b0;
    logic        cts_in = 1'b0;
    logic        rts_out, irq;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_irq_ctl u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .rx_push(rx_push), .rx_byte(rx_byte), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_avail(tx_avail),
        .baud_tick(baud_tick), .cts_in(cts_in), .rts_out(rts_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic bwr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
        @(posedge clk); #1; sel = 0; wr = 0;
    endtask

    task automatic brd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); sel = 1; wr = 0; addr = a;
        #2; d = rdata;
        @(posedge clk); #1; sel = 0;
    endtask

    task automatic rpush(input logic [7:0] b, input logic fe, input logic bk);
        @(negedge clk); rx_push = 1; rx_byte = b; rx_ferr = fe; rx_brk = bk;
        @(posedge clk); #1; rx_push = 0; rx_ferr = 0; rx_brk = 0;
    endtask

    task automatic tpop(output logic [7:0] b);
        @(negedge clk); #2; b = tx_byte; tx_pop = 1;
        @(posedge clk); #1; tx_pop = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        brd(5'h04, d); chk("R1 level", d, 0);
        brd(5'h08, d); chk("R1 status", d, 0);
        brd(5'h0C, d); chk("R1 ctrl", d, 0);
        brd(5'h10, d); chk("R1 rate", d, 0);
        chk("R1 irq", irq, 0);
        chk("R1 tx_avail", tx_avail, 0);
        chk("R1 rts_out", rts_out, 1);
        brd(5'h00, d); chk("R1 empty read", d, 32'h100);
    endtask

    task automatic t_rx_word();
        logic [31:0] d;
        rpush(8'h5A, 0, 0); rpush(8'h33, 1, 0); rpush(8'h00, 0, 1);
        brd(5'h04, d); chk("R3 rx level", d, 32'h0003);
        brd(5'h08, d); chk("R8 status frame+break+trig", d, 32'h1A);
        brd(5'h00, d); chk("R2 plain byte", d, 32'h05A);
        brd(5'h00, d); chk("R2 framing flag", d, 32'h233);
        brd(5'h00, d); chk("R2 break flag", d, 32'h400);
        brd(5'h00, d); chk("R2 empty flag", d, 32'h100);
        brd(5'h08, d); chk("R8 latched after drain", d, 32'h18);
        bwr(5'h08, 32'h18);
        brd(5'h08, d); chk("R8 write-1 clear", d, 0);
    endtask

    task automatic t_trigger();
        logic [31:0] d;
        bwr(5'h0C, (2 << 2) | (1 << 6));
        for (int i = 0; i < 7; i++) rpush(8'(i), 0, 0);
        brd(5'h08, d); chk("R6 below trigger", d[1], 0);
        chk("R10 irq off below trigger", irq, 0);
        rpush(8'h07, 0, 0);
        brd(5'h08, d); chk("R6 at trigger", d[1], 1);
        chk("R10 rx irq", irq, 1);
        brd(5'h00, d);
        brd(5'h08, d); chk("R6 drained below", d[1], 0);
        chk("R10 irq drops", irq, 0);
        for (int i = 0; i < 7; i++) brd(5'h00, d);
        brd(5'h04, d); chk("R3 rx empty again", d, 0);
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        int bad;
        bwr(5'h0C, 1 << 7);
        for (int i = 0; i < 65; i++) rpush(8'(i), 0, 0);
        brd(5'h04, d); chk("R4 rx level capped", d, 32'h0040);
        brd(5'h08, d); chk("R4 overrun latched", d[5], 1);
        chk("R10 error irq", irq, 1);
        bwr(5'h08, 32'h20);
        brd(5'h08, d); chk("R4 overrun cleared", d[5], 0);
        chk("R10 error irq cleared", irq, 0);
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            brd(5'h00, d);
            if (d != 32'(i)) bad++;
        end
        chk("R4 order kept, extra byte dropped", 32'(bad), 0);
        brd(5'h00, d); chk("R2 empty after drain", d, 32'h100);
    endtask

    task automatic t_tx();
        logic [31:0] d;
        logic [7:0] b;
        int bad;
        bwr(5'h0C, 2 | (1 << 5));
        for (int i = 0; i < 65; i++) bwr(5'h00, 32'(i));
        brd(5'h04, d); chk("R5 tx level capped", d, 32'h4000);
        chk("R11 tx_avail without gating", tx_avail, 1);
        bad = 0;
        for (int i = 0; i < 55; i++) begin
            tpop(b);
            if (b != 8'(i)) bad++;
        end
        brd(5'h08, d); chk("R7 above tx level", d[0], 0);
        tpop(b); if (b != 8'd55) bad++;
        brd(5'h08, d); chk("R7 tx latch set at level", d[0], 1);
        chk("R10 tx irq", irq, 1);
        bwr(5'h08, 32'h01);
        brd(5'h08, d); chk("R7 tx latch cleared", d[0], 0);
        chk("R10 tx irq cleared", irq, 0);
        bwr(5'h08, 32'h40);
        brd(5'h08, d); chk("R7 software set", d, 32'h01);
        bwr(5'h08, 32'h01);
        for (int i = 56; i < 64; i++) begin
            tpop(b);
            if (b != 8'(i)) bad++;
        end
        chk("R5 tx order, extra write ignored", 32'(bad), 0);
        chk("R11 tx_avail when empty", tx_avail, 0);
        bwr(5'h08, 32'h01);
        bwr(5'h0C, 0);
    endtask

    task automatic t_cts();
        logic [31:0] d;
        logic [7:0] b;
        bwr(5'h00, 32'h77);
        bwr(5'h0C, 1 << 14);
        cts_in = 0; #2;
        chk("R11 blocked", tx_avail, 0);
        tpop(b);
        brd(5'h04, d); chk("R11 pop ignored while blocked", d, 32'h0100);
        cts_in = 1; #2;
        chk("R11 allowed", tx_avail, 1);
        bwr(5'h0C, (1 << 14) | (1 << 15));
        cts_in = 0; #2;
        chk("R11 inverted allowed", tx_avail, 1);
        cts_in = 1; #2;
        chk("R11 inverted blocked", tx_avail, 0);
        bwr(5'h0C, 0);
        tpop(b); chk("R11 byte after gating", b, 8'h77);
        cts_in = 0;
    endtask

    task automatic t_rts();
        logic [31:0] d;
        bwr(5'h0C, 1 << 18);
        for (int i = 0; i < 7; i++) rpush(8'(i), 0, 0);
        #1; chk("R12 ready below 8", rts_out, 1);
        rpush(8'h07, 0, 0);
        #1; chk("R12 deasserted at 8", rts_out, 0);
        bwr(5'h0C, (1 << 18) | (1 << 21));
        chk("R12 inverted", rts_out, 1);
        bwr(5'h0C, 0);
        chk("R12 disabled", rts_out, 1);
        for (int i = 0; i < 8; i++) brd(5'h00, d);
    endtask

    task automatic t_timeout();
        logic [31:0] d;
        bwr(5'h0C, (1 << 16) | (1 << 6) | (5 << 2));
        baud_tick = 1;
        rpush(8'hC1, 0, 0);
        repeat (30) @(posedge clk); #1;
        chk("R9 not yet timed out", u0.bus_rdata === u0.bus_rdata ? irq : 1'b1, 0);
        brd(5'h08, d); chk("R9 status before limit", d[2], 0);
        repeat (20) @(posedge clk); #1;
        brd(5'h08, d); chk("R9 timed out", d[2], 1);
        chk("R10 timeout irq", irq, 1);
        rpush(8'hC2, 0, 0);
        brd(5'h08, d); chk("R9 push restarts", d[2], 0);
        repeat (50) @(posedge clk); #1;
        brd(5'h08, d); chk("R9 timed out again", d[2], 1);
        brd(5'h00, d); chk("R2 first timed byte", d, 32'h0C1);
        brd(5'h08, d); chk("R9 read restarts", d[2], 0);
        brd(5'h00, d);
        repeat (50) @(posedge clk); #1;
        brd(5'h08, d); chk("R9 silent when empty", d[2], 0);
        baud_tick = 0;
        bwr(5'h0C, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        bwr(5'h10, 32'hAB);
        brd(5'h10, d); chk("R13 rate", d, 32'hAB);
        bwr(5'h10, 32'h1FF);
        brd(5'h10, d); chk("R13 rate width", d, 32'hFF);
        bwr(5'h0C, 32'hFFFF_FFFF);
        brd(5'h0C, d); chk("R13 ctrl width", d, 32'h3F_FFFF);
        bwr(5'h0C, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_rx_word();
        t_trigger();
        t_overrun();
        t_tx();
        t_cts();
        t_rts();
        t_timeout();
        t_regs();
        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule